// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and each bank has its own set of word-wide registers. Software controls the output latches only through separate write-one-to-set and write-one-to-clear strobe words, never by rewriting the level. It chooses each pin's direction, reads back the live state of every pin, and arms per-pin detection of rising and falling transitions. Detected transitions are recorded in a sticky status word that is cleared by writing ones. Each bank also has an interrupt mask word, and all unmasked status bits are merged into one registered interrupt line.

Register words of the same kind for different banks sit next to each other in the address map. Each kind has its own base, and banks 0 to 2 occupy the first three words of every kind. Banks 3 to 5 repeat that layout 0x100 bytes higher. The pad is outside the block: it gets an output value and an output enable per pin and returns the sampled pin level.

Top module: `gpio_ctrl`

## Requirements
- R1: After synchronous reset, every pin is an input (`pin_oe` all zero, including pins with inverted direction sense), every output latch is 0, `irq` is 0, and the edge enables, edge status and interrupt masks read as 0.
- R2: The word of kind K for bank b sits at byte address base(K) + 4*b for b in 0..2 and at base(K) + 0x100 + 4*(b-3) for b in 3..5. The bases are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, interrupt mask 0x9C. A read of an address that selects no implemented bank returns 0, and a write to it changes nothing.
- R3: A write to a set word drives high each output latch whose data bit is 1, and a write to a clear word drives low each latch whose data bit is 1. Latches whose data bit is 0 keep their value. The set and clear words read as 0. Read data appears on `reg_rdata` one cycle after the read is accepted.
- R4: A direction bit of 1 makes its pin an output and 0 makes it an input. For pins listed in the parameter `INV_DIR_MASK` the sense is reversed, and their direction bit resets to 1.
- R5: The level word returns the synchronized state of every pin of the bank, inputs and outputs alike. Writes to the level word have no effect.
- R6: Pin inputs pass through two flops. A low-to-high change of a pin whose rising-enable bit is 1 sets its status bit, and a high-to-low change of a pin whose falling-enable bit is 1 sets it. With both enables set, either change sets it. A change on a pin with the matching enable at 0 leaves the bit unchanged.
- R7: Status bits stay set until a write to the edge status word with a 1 in their position. Zero bits of that write leave the status unchanged.
- R8: If a new enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R9: `irq` is the registered OR over all banks of status bits ANDed with their interrupt mask bits (1 = pass). A change on a pin shows up on `irq` on the fourth clock edge after the change.
- R10: In the last bank, bits above the implemented pin count read as 0 in every word and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_PINS | Sampled pin levels from the pads |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the controller with 108 pins and one inverted-direction pin (pin 100). That gives four banks, so the decoder's 0x100 region for bank 3 is used. The last bank has only 12 valid bits, which exercises the masking of unused positions, and a bank 4 address is present but not implemented. The inverted pin sits in that partial bank, so the reset value and the inverted output-enable sense can be seen on the ports. The pads are modelled as looping back driven pins, so the level readback of outputs and inputs is checked in the same word.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 9;
    localparam int MAX_BANKS = 6;

    // Register kinds; the numeric order matches the order of the kind bases
    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_DIR   = 3'd1,
        RK_SET   = 3'd2,
        RK_CLR   = 3'd3,
        RK_RISE  = 3'd4,
        RK_FALL  = 3'd5,
        RK_STAT  = 3'd6,
        RK_IMASK = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [2:0] bank;
    } reg_sel_t;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic stat;
        logic imask;
    } bank_we_t;

    // Kinds 0..6 take three words each from word 0; the mask kind starts at word 39 (0x9C)
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr, input int nbank);
        reg_sel_t s;
        int       w;
        int       sub;
        int       bk;
        logic     found;
        s     = '0;
        sub   = 0;
        found = 1'b0;
        w     = int'(addr[7:2]);
        for (int i = 0; i < 7; i++) begin
            if (w >= 3 * i && w < 3 * i + 3) begin
                s.kind = reg_kind_e'(3'(i));
                sub    = w - 3 * i;
                found  = 1'b1;
            end
        end
        if (w >= 39 && w <= 41) begin
            s.kind = RK_IMASK;
            sub    = w - 39;
            found  = 1'b1;
        end
        bk     = addr[8] ? sub + 3 : sub;
        s.bank = 3'(bk);
        s.hit  = found && (bk < nbank) && (addr[1:0] == 2'b00);
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] valid_bits(input int n);
        if (n >= WORD_W) return '1;
        return (WORD_W'(1) << n) - WORD_W'(1);
    endfunction

    function automatic int bank_pins(input int total, input int b);
        int rem;
        rem = total - WORD_W * b;
        return (rem >= WORD_W) ? WORD_W : rem;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= raw;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int               PINS = 32,
    parameter logic [WORD_W-1:0] INV = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_we_t          we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] lvl,
    input  logic [WORD_W-1:0] lvl_prev,
    output logic [WORD_W-1:0] dir_q,
    output logic [WORD_W-1:0] out_q,
    output logic [WORD_W-1:0] oe,
    output logic [WORD_W-1:0] rise_q,
    output logic [WORD_W-1:0] fall_q,
    output logic [WORD_W-1:0] stat_q,
    output logic [WORD_W-1:0] imask_q,
    output logic              pend
);
    localparam logic [WORD_W-1:0] VM    = valid_bits(PINS);
    localparam logic [WORD_W-1:0] INV_V = INV & VM;

    logic [WORD_W-1:0] evt;
    logic [WORD_W-1:0] w1c;
    logic [WORD_W-1:0] stat_d;

    always_comb begin
        evt    = ((rise_q & lvl & ~lvl_prev) | (fall_q & ~lvl & lvl_prev)) & VM;
        w1c    = we.stat ? wdata : '0;
        // a fresh edge wins over a clear in the same cycle
        stat_d = (stat_q & ~w1c) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= INV_V;
            out_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            stat_q  <= '0;
            imask_q <= '0;
        end else begin
            if (we.dir)   dir_q   <= wdata & VM;
            if (we.set)   out_q   <= out_q | (wdata & VM);
            else if (we.clr) out_q <= out_q & ~wdata;
            if (we.rise)  rise_q  <= wdata & VM;
            if (we.fall)  fall_q  <= wdata & VM;
            if (we.imask) imask_q <= wdata & VM;
            stat_q <= stat_d;
        end
    end

    assign oe   = (dir_q ^ INV_V) & VM;
    assign pend = |(stat_q & imask_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int                  NUM_PINS     = 64,
    parameter logic [NUM_PINS-1:0] INV_DIR_MASK = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [8:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    // at most MAX_BANKS banks are addressable
    localparam int NBANK = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PADW  = NBANK * WORD_W;
    localparam logic [PADW-1:0] INV_PAD = PADW'(INV_DIR_MASK);

    logic [NUM_PINS-1:0] lvl_s, lvl_p;
    logic [PADW-1:0]     lvl_pad, prev_pad, out_pad, oe_pad, stat_pad;
    logic [WORD_W-1:0]   dir_w [NBANK];
    logic [WORD_W-1:0]   out_w [NBANK];
    logic [WORD_W-1:0]   oe_w  [NBANK];
    logic [WORD_W-1:0]   rise_w[NBANK];
    logic [WORD_W-1:0]   fall_w[NBANK];
    logic [WORD_W-1:0]   stat_w[NBANK];
    logic [WORD_W-1:0]   imsk_w[NBANK];
    logic [NBANK-1:0]    pend;
    reg_sel_t            sel;
    logic [WORD_W-1:0]   rd_d;
    logic                rd_q_irq;

    gpio_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (pin_in),
        .cur (lvl_s),
        .prev(lvl_p)
    );

    assign lvl_pad  = PADW'(lvl_s);
    assign prev_pad = PADW'(lvl_p);
    assign sel      = decode_addr(reg_addr, NBANK);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_we_t we_b;
        logic     hit_b;
        assign hit_b      = reg_en && reg_we && sel.hit && (sel.bank == 3'(b));
        assign we_b.dir   = hit_b && (sel.kind == RK_DIR);
        assign we_b.set   = hit_b && (sel.kind == RK_SET);
        assign we_b.clr   = hit_b && (sel.kind == RK_CLR);
        assign we_b.rise  = hit_b && (sel.kind == RK_RISE);
        assign we_b.fall  = hit_b && (sel.kind == RK_FALL);
        assign we_b.stat  = hit_b && (sel.kind == RK_STAT);
        assign we_b.imask = hit_b && (sel.kind == RK_IMASK);

        gpio_bank #(
            .PINS(bank_pins(NUM_PINS, b)),
            .INV (INV_PAD[b*WORD_W +: WORD_W])
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (we_b),
            .wdata   (reg_wdata),
            .lvl     (lvl_pad[b*WORD_W +: WORD_W]),
            .lvl_prev(prev_pad[b*WORD_W +: WORD_W]),
            .dir_q   (dir_w[b]),
            .out_q   (out_w[b]),
            .oe      (oe_w[b]),
            .rise_q  (rise_w[b]),
            .fall_q  (fall_w[b]),
            .stat_q  (stat_w[b]),
            .imask_q (imsk_w[b]),
            .pend    (pend[b])
        );

        assign out_pad [b*WORD_W +: WORD_W] = out_w[b];
        assign oe_pad  [b*WORD_W +: WORD_W] = oe_w[b];
        assign stat_pad[b*WORD_W +: WORD_W] = stat_w[b];
    end

    assign pin_out = out_pad[NUM_PINS-1:0];
    assign pin_oe  = oe_pad[NUM_PINS-1:0];

    always_comb begin
        rd_d = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (sel.hit && sel.bank == 3'(b)) begin
                case (sel.kind)
                    RK_LEVEL: rd_d = lvl_pad[b*WORD_W +: WORD_W];
                    RK_DIR:   rd_d = dir_w[b];
                    RK_RISE:  rd_d = rise_w[b];
                    RK_FALL:  rd_d = fall_w[b];
                    RK_STAT:  rd_d = stat_w[b];
                    RK_IMASK: rd_d = imsk_w[b];
                    default:  rd_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            rd_q_irq  <= 1'b0;
        end else begin
            if (reg_en && !reg_we) reg_rdata <= rd_d;
            rd_q_irq <= |pend;
        end
    end

    assign irq = rd_q_irq;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int NUM_PINS = 64,
    parameter int PADW     = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_en,
    input logic                reg_we,
    input logic [8:0]          reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [PADW-1:0]     stat_flat
);
    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq));                              // R1

    AST_SET_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 9'h018 && reg_wdata[0]) |=> pin_out[0]);             // R3

    AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 9'h024 && reg_wdata[0]) |=> !pin_out[0]);            // R3

    AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_oe) |-> $past(reg_en && reg_we));                                        // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_flat) & ~stat_flat)) |-> $past(reg_en && reg_we));                      // R7

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|stat_flat));                                                           // R9
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS), .PADW(PADW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .stat_flat(stat_pad)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 108;
    localparam logic [NP-1:0] INV = NP'(1) << 100;

    localparam logic [8:0] K_LVL = 9'h000, K_DIR = 9'h00C, K_SET = 9'h018, K_CLR = 9'h024,
                           K_RISE = 9'h030, K_FALL = 9'h03C, K_STAT = 9'h048, K_MSK = 9'h09C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_en = 1'b0, reg_we = 1'b0;
    logic [8:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] ext = '0;
    logic [NP-1:0] pin_in, pin_out, pin_oe;
    logic          irq;

    int  errs = 0;
    int  checks = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pad model: driven pins loop back, others follow the external level
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_ctrl #(.NUM_PINS(NP), .INV_DIR_MASK(INV)) u_dut (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [8:0] ra(input logic [8:0] base, input int bank);
        if (bank < 3) return base + 9'(4 * bank);
        return base + 9'h100 + 9'(4 * (bank - 3));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks are entered just after a falling edge
    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 oe low", pin_oe[31:0] | pin_oe[107:96], 32'h0);
        chk("R1 out low", pin_out[31:0] | pin_out[107:96], 32'h0);
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        bus_rd(ra(K_STAT, 1), d); chk("R1 status", d, 32'h0);
        bus_rd(ra(K_RISE, 0), d); chk("R1 rise enable", d, 32'h0);
        bus_rd(ra(K_DIR, 3), d);  chk("R4 inverted dir reset", d, 32'h0000_0010);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        bus_wr(ra(K_DIR, 0), 32'h0000_00FF);
        chk("R4 oe bank0", pin_oe[31:0], 32'h0000_00FF);
        bus_wr(ra(K_SET, 0), 32'h0000_00A5);
        chk("R3 set", {24'b0, pin_out[7:0]}, 32'hA5);
        bus_wr(ra(K_CLR, 0), 32'h0000_0021);
        chk("R3 clear", {24'b0, pin_out[7:0]}, 32'h84);
        bus_wr(ra(K_SET, 0), 32'h0);
        chk("R3 zero set keeps", {24'b0, pin_out[7:0]}, 32'h84);
        bus_rd(ra(K_SET, 0), d); chk("R3 set reads zero", d, 32'h0);
        bus_wr(ra(K_DIR, 3), 32'h0000_0001);
        chk("R4 inverted oe", {20'b0, pin_oe[107:96]}, 32'h011);
        bus_wr(ra(K_SET, 3), 32'h0000_0001);
        chk("R2 bank3 set", {20'b0, pin_out[107:96]}, 32'h001);
        idle(3);
        bus_rd(ra(K_LVL, 3), d); chk("R2 bank3 level", d, 32'h001);
    endtask

    task automatic t_level();
        logic [31:0] d;
        ext[63:32] = 32'h1234_5678;
        ext[31:0]  = 32'h5A5A_5A00;
        idle(3);
        bus_rd(ra(K_LVL, 1), d); chk("R5 input level", d, 32'h1234_5678);
        bus_rd(ra(K_LVL, 0), d); chk("R5 mixed level", d, 32'h5A5A_5A84);
        bus_wr(ra(K_LVL, 1), 32'hFFFF_FFFF);
        idle(3);
        bus_rd(ra(K_LVL, 1), d); chk("R5 level write ignored", d, 32'h1234_5678);
        ext[63:32] = 32'h0;
        idle(3);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        bus_wr(ra(K_MSK, 1), 32'hFFFF_FFFF);
        bus_wr(ra(K_RISE, 1), 32'h0000_0005);
        bus_wr(ra(K_FALL, 1), 32'h0000_0006);
        // rising edge on pin 32, irq latency
        ext[32] = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 irq not yet", {31'b0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R9 irq after four edges", {31'b0, irq}, 32'h1);
        bus_rd(ra(K_STAT, 1), d); chk("R6 rise sets", d, 32'h1);
        bus_wr(ra(K_STAT, 1), 32'h0000_0002);
        bus_rd(ra(K_STAT, 1), d); chk("R7 zero bit keeps", d, 32'h1);
        bus_wr(ra(K_STAT, 1), 32'h0000_0001);
        bus_rd(ra(K_STAT, 1), d); chk("R7 one clears", d, 32'h0);
        ext[32] = 1'b0;
        idle(5);
        bus_rd(ra(K_STAT, 1), d); chk("R6 fall ignored when disabled", d, 32'h0);
        // pin 33 falling only
        ext[33] = 1'b1;
        idle(5);
        bus_rd(ra(K_STAT, 1), d); chk("R6 rise ignored when disabled", d, 32'h0);
        ext[33] = 1'b0;
        idle(5);
        bus_rd(ra(K_STAT, 1), d); chk("R6 fall sets", d, 32'h2);
        bus_wr(ra(K_STAT, 1), 32'hFFFF_FFFF);
        // pin 34 both edges, masked off
        bus_wr(ra(K_MSK, 1), 32'h0);
        ext[34] = 1'b1;
        idle(5);
        bus_rd(ra(K_STAT, 1), d); chk("R6 both enables rise", d, 32'h4);
        chk("R9 masked no irq", {31'b0, irq}, 32'h0);
        bus_wr(ra(K_MSK, 1), 32'h0000_0004);
        idle(2);
        chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_race();
        logic [31:0] d;
        // status bit 2 is set; a falling edge lands with its clear
        ext[34] = 1'b0;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        bus_wr(ra(K_STAT, 1), 32'h0000_0004);
        bus_rd(ra(K_STAT, 1), d); chk("R8 edge beats clear", d, 32'h4);
        bus_wr(ra(K_STAT, 1), 32'h0000_0004);
        bus_rd(ra(K_STAT, 1), d); chk("R7 later clear", d, 32'h0);
        idle(2);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_lastbank();
        logic [31:0] d;
        logic [NP-1:0] oe_before;
        bus_wr(ra(K_DIR, 3), 32'hFFFF_FFFF);
        bus_rd(ra(K_DIR, 3), d); chk("R10 dir unused bits", d, 32'h0000_0FFF);
        chk("R10 oe with inverted pin", {20'b0, pin_oe[107:96]}, 32'hFEF);
        bus_wr(ra(K_SET, 3), 32'hFFFF_FFFF);
        chk("R10 set last bank", {20'b0, pin_out[107:96]}, 32'hFFF);
        bus_wr(ra(K_MSK, 3), 32'hFFFF_FFFF);
        bus_rd(ra(K_MSK, 3), d); chk("R10 mask unused bits", d, 32'h0000_0FFF);
        oe_before = pin_oe;
        bus_wr(ra(K_DIR, 4), 32'hFFFF_FFFF);
        chk("R2 absent bank write", (pin_oe == oe_before) ? 32'h1 : 32'h0, 32'h1);
        bus_rd(ra(K_DIR, 4), d); chk("R2 absent bank read", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_level();
        t_edge();
        t_race();
        t_lastbank();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule